// File: doc/BRIEF.md
# HDLC Transmit Framer With Idle Fill

This block turns queued frames into a serial HDLC bit stream for one B or D channel. It sits between a frame-indexed transmit FIFO and the line-side serializer. It produces one line bit for each `bit_en` strobe. With nothing queued it repeats the flag octet `0x7E` without touching the FIFO. When the FIFO reports a queued frame at a flag boundary, the framer pulses `frame_adv` to move the FIFO's read-frame counter onto that frame. It then pulls the frame's bytes with `rd_en` and sends them least significant bit first, inserting a zero after every run of five ones. When the FIFO reports that the frame's end pointer has been reached (`byte_avail` low at a byte fetch), the framer appends the complemented CRC-16 and a closing flag on its own. The closing flag also opens the next frame if one is already waiting.

The control is a four-state machine:

- **IDLE** sends idle flags. When the eighth bit of a flag goes out with `frame_avail` high, IDLE moves to DATA; otherwise it stays in IDLE.
- **DATA** takes a byte between strobes whenever its byte register is empty. If the FIFO has no byte left for the frame, DATA moves to FCS.
- **FCS** shifts out the 16 check bits. After the last check bit (and any zero still owed), the next strobe sends flag bit 0 and moves to CLOSE.
- **CLOSE** finishes the closing flag and pulses `frame_done`. From there it moves to DATA if another frame is waiting, or to IDLE if not.

The FIFO is expected to update `byte_avail` and `rd_data` in the cycle after it sees `frame_adv` or `rd_en`. `bit_en` strobes must be at least four clock cycles apart.

Top module: `hdlc_tx_framer`

## Requirements
- R1: After reset, `tx_bit` is 1 and `rd_en`, `frame_adv` and `frame_done` are 0.
- R2: While no frame is queued, each strobe sends the next bit of the flag `0x7E`, taken least significant bit first (0,1,1,1,1,1,1,0), and `rd_en` and `frame_adv` stay low.
- R3: A new frame starts only after the eighth bit of a flag. At that strobe `frame_adv` is a single-cycle pulse, raised only if `frame_avail` was high.
- R4: Each byte of a frame is fetched with a single-cycle `rd_en` and sent least significant bit first, in FIFO order.
- R5: After five consecutive ones in the data or check field, the next bit sent is an inserted 0. Runs of ones carry across byte and field boundaries, and flags are never stuffed.
- R6: When `byte_avail` is low at a byte fetch, the framer sends 16 check bits, least significant bit first. The check bits are the ones' complement of a CRC over the data bits with reflected polynomial `0x8408` (x^16+x^12+x^5+1) and preset `0xFFFF`. A frame with no bytes therefore sends 16 zeros.
- R7: A closing flag follows the check bits. `frame_done` pulses for one cycle together with the strobe that sends the flag's eighth bit, and at no other time.
- R8: If another frame is queued when the closing flag ends, `frame_adv` is raised at that same strobe and the next data bit follows with no idle flag in between.
- R9: In a cycle without `bit_en`, `tx_bit` and the framer's position in the stream do not change.
- R10: `rd_en` is raised only during a frame, and only when `byte_avail` was high in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Strobe: produce one line bit |
| frame_avail | input | 1 | FIFO has at least one queued frame not yet started |
| byte_avail | input | 1 | Current frame still has an unread byte |
| rd_data | input | 8 | Byte at the FIFO read pointer |
| rd_en | output | 1 | Pop one byte from the FIFO |
| frame_adv | output | 1 | Advance the FIFO read-frame counter |
| tx_bit | output | 1 | Serial HDLC output bit |
| frame_done | output | 1 | Closing flag fully sent |

## Verification
The stream is checked bit by bit against a model built from the requirements, using several kinds of frame:

- A short mixed-pattern frame confirms bit order and check-sequence value.
- Frames dense in ones, including a payload that contains the flag octet, separate correct zero insertion from insertion that misses a run, crosses into the flags, or resets at byte edges.
- An empty frame shows that the check field is produced from the preset alone.
- Two frames queued together tell a shared closing/opening flag apart from an extra idle flag.
- A long strobe pause in mid-frame shows that nothing moves without `bit_en`.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DATA,
        ST_FCS,
        ST_CLOSE
    } tx_state_e;

    localparam int FLAG_W = 8;
    localparam int FLAG_IDX_W = $clog2(FLAG_W);
    localparam logic [FLAG_W-1:0] FLAG_PAT = 8'h7E;

endpackage

// File: rtl/hdlc_crc_serial.sv
module hdlc_crc_serial #(
    parameter int W = 16,
    parameter logic [W-1:0] POLY = 'h8408,
    parameter logic [W-1:0] INIT = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] crc_q
);

    logic         fb;
    logic [W-1:0] crc_n;

    always_comb begin
        fb    = crc_q[0] ^ din;
        crc_n = (crc_q >> 1) ^ (fb ? POLY : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            crc_q <= INIT;
        end else if (shift) begin
            crc_q <= crc_n;
        end
    end

endmodule

// File: rtl/hdlc_run_counter.sv
module hdlc_run_counter #(
    parameter int RUN_LEN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic upd,
    input  logic bit_in,
    output logic stuff_due
);

    localparam int RW = $clog2(RUN_LEN + 1);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            run_q <= '0;
        end else if (upd) begin
            run_q <= bit_in ? run_q + 1'b1 : '0;
        end
    end

    assign stuff_due = (run_q == RW'(RUN_LEN));

    // R5: a sixth one in a row would mean a missed insertion
    assert_run_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RW'(RUN_LEN));

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
    import hdlc_tx_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int CRC_W = 16,
    parameter int RUN_LEN = 5,
    parameter logic [CRC_W-1:0] CRC_POLY = 'h8408,
    parameter logic [CRC_W-1:0] CRC_INIT = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              frame_avail,
    input  logic              byte_avail,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              rd_en,
    output logic              frame_adv,
    output logic              tx_bit,
    output logic              frame_done
);

    localparam int CNT_MAX = (CRC_W > BYTE_W) ? CRC_W : BYTE_W;
    localparam int CNT_W = $clog2(CNT_MAX + 1);

    tx_state_e         state, state_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic [BYTE_W-1:0] dsh, dsh_n;
    logic              have, have_n;
    logic [CRC_W-1:0]  fsh, fsh_n;
    logic              tx_n, rd_n, adv_n, done_n;
    logic              crc_clr, crc_shift;
    logic              run_clr, run_upd, run_bit, stuff_due;
    logic [CRC_W-1:0]  crc_q;

    hdlc_crc_serial #(.W(CRC_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
        .clk(clk), .rst_n(rst_n), .clr(crc_clr), .shift(crc_shift),
        .din(dsh[0]), .crc_q(crc_q)
    );

    hdlc_run_counter #(.RUN_LEN(RUN_LEN)) u_run (
        .clk(clk), .rst_n(rst_n), .clr(run_clr), .upd(run_upd),
        .bit_in(run_bit), .stuff_due(stuff_due)
    );

    always_comb begin
        state_n   = state;
        cnt_n     = cnt;
        dsh_n     = dsh;
        have_n    = have;
        fsh_n     = fsh;
        tx_n      = tx_bit;
        rd_n      = 1'b0;
        adv_n     = 1'b0;
        done_n    = 1'b0;
        crc_clr   = 1'b0;
        crc_shift = 1'b0;
        run_clr   = 1'b0;
        run_upd   = 1'b0;
        run_bit   = 1'b0;
        unique case (state)
            ST_IDLE, ST_CLOSE: begin
                if (bit_en) begin
                    tx_n    = FLAG_PAT[cnt[FLAG_IDX_W-1:0]];
                    run_clr = 1'b1;
                    if (cnt == CNT_W'(FLAG_W - 1)) begin
                        cnt_n  = '0;
                        done_n = (state == ST_CLOSE);
                        if (frame_avail) begin
                            adv_n   = 1'b1;
                            crc_clr = 1'b1;
                            have_n  = 1'b0;
                            state_n = ST_DATA;
                        end else begin
                            state_n = ST_IDLE;
                        end
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (!have) begin
                    // fetch between strobes; wait one cycle after a frame advance
                    if (!frame_adv) begin
                        cnt_n = '0;
                        if (byte_avail) begin
                            dsh_n  = rd_data;
                            have_n = 1'b1;
                            rd_n   = 1'b1;
                        end else begin
                            fsh_n   = ~crc_q;
                            state_n = ST_FCS;
                        end
                    end
                end else if (bit_en) begin
                    run_upd = 1'b1;
                    if (stuff_due) begin
                        tx_n = 1'b0;
                    end else begin
                        tx_n      = dsh[0];
                        run_bit   = dsh[0];
                        crc_shift = 1'b1;
                        dsh_n     = dsh >> 1;
                        if (cnt == CNT_W'(BYTE_W - 1)) begin
                            have_n = 1'b0;
                            cnt_n  = '0;
                        end else begin
                            cnt_n = cnt + 1'b1;
                        end
                    end
                end
            end
            ST_FCS: begin
                if (bit_en) begin
                    if (stuff_due) begin
                        tx_n    = 1'b0;
                        run_upd = 1'b1;
                    end else if (cnt == CNT_W'(CRC_W)) begin
                        tx_n    = FLAG_PAT[0];
                        run_clr = 1'b1;
                        cnt_n   = CNT_W'(1);
                        state_n = ST_CLOSE;
                    end else begin
                        tx_n    = fsh[0];
                        run_upd = 1'b1;
                        run_bit = fsh[0];
                        fsh_n   = fsh >> 1;
                        cnt_n   = cnt + 1'b1;
                    end
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dsh        <= '0;
            have       <= 1'b0;
            fsh        <= '0;
            tx_bit     <= 1'b1;
            rd_en      <= 1'b0;
            frame_adv  <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            dsh        <= dsh_n;
            have       <= have_n;
            fsh        <= fsh_n;
            tx_bit     <= tx_n;
            rd_en      <= rd_n;
            frame_adv  <= adv_n;
            frame_done <= done_n;
        end
    end

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(tx_bit));

    assert_adv_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_adv |=> !frame_adv);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    assert_rd_guard_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> $past(byte_avail));

    assert_idle_noread_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !rd_en);

    assert_adv_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_adv |-> $past(frame_avail));

endmodule

// File: tb/sim_hdlc_tx_framer.sv
`timescale 1ns/1ps
module sim_hdlc_tx_framer;

    typedef struct {
        bit b;
        bit last;
        int req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       frame_avail, byte_avail;
    logic [7:0] rd_data;
    logic       rd_en, frame_adv, tx_bit, frame_done;

    always #10 clk = ~clk;

    hdlc_tx_framer u0 (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
        .frame_avail(frame_avail), .byte_avail(byte_avail), .rd_data(rd_data),
        .rd_en(rd_en), .frame_adv(frame_adv), .tx_bit(tx_bit), .frame_done(frame_done)
    );

    // FIFO model
    logic [7:0] mem [0:255];
    int fstart [0:15];
    int flen [0:15];
    int frames_written = 0;
    int wr_ptr = 0;
    int fs, rp, cur;
    logic [7:0] tbuf [0:15];

    always @(posedge clk) begin
        if (!rst_n) begin
            fs <= 0;
            rp <= 0;
        end else if (frame_adv) begin
            fs <= fs + 1;
            rp <= 0;
        end else if (rd_en) begin
            rp <= rp + 1;
        end
    end

    assign cur         = (fs == 0) ? 0 : fs - 1;
    assign frame_avail = frames_written > fs;
    assign byte_avail  = (fs > 0) && (rp < flen[cur]);
    assign rd_data     = mem[(fstart[cur] + rp) & 255];

    // scoreboard
    exp_t sbq [$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   active = 0;
    int   phase = 0;
    bit   pause = 0;
    bit   se_q = 0;
    bit   finished = 0;
    localparam logic [7:0] FLAG = 8'h7E;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input bit b, input bit last, input int req);
        exp_t e;
        e.b = b;
        e.last = last;
        e.req = req;
        sbq.push_back(e);
    endtask

    // driver: store the frame in the FIFO model and queue its expected bits
    task automatic queue_frame(input int n);
        logic [15:0] crc;
        int ones;
        bit b, fb;
        fstart[frames_written] = wr_ptr;
        flen[frames_written] = n;
        crc = 16'hFFFF;
        ones = 0;
        for (int i = 0; i < n; i++) begin
            mem[wr_ptr] = tbuf[i];
            wr_ptr++;
            for (int j = 0; j < 8; j++) begin
                b = tbuf[i][j];
                push(b, 0, 4);            // R4 data bit
                fb = crc[0] ^ b;
                crc = crc >> 1;
                if (fb) crc = crc ^ 16'h8408;
                ones = b ? ones + 1 : 0;
                if (ones == 5) begin
                    push(0, 0, 5);        // R5 inserted zero
                    ones = 0;
                end
            end
        end
        crc = ~crc;
        for (int j = 0; j < 16; j++) begin
            b = crc[j];
            push(b, 0, 6);                // R6 check bit
            ones = b ? ones + 1 : 0;
            if (ones == 5) begin
                push(0, 0, 5);
                ones = 0;
            end
        end
        for (int j = 0; j < 8; j++) push(FLAG[j], j == 7, 7);   // R7 closing flag
        frames_written++;
    endtask

    task automatic wait_idle();
        while (sbq.size() != 0 || active || frames_written != fs) @(negedge clk);
        repeat (40) @(negedge clk);
    endtask

    // strobe generator: one strobe every four cycles
    initial begin
        int c;
        c = 1;
        wait (rst_n);
        forever begin
            @(negedge clk);
            c = (c + 1) % 4;
            bit_en = (c == 0) && !pause;
        end
    end

    always @(posedge clk) se_q <= bit_en;

    // monitor
    initial begin
        exp_t it;
        bit pending;
        forever begin
            @(negedge clk);
            if (rst_n && rd_en) chk("R10 rd_en inside frame", active, 1);
            if (rst_n && se_q) begin
                if (active) begin
                    if (sbq.size() == 0) begin
                        chk("R3 unexpected frame start", 0, 1);
                        active = 0;
                    end else begin
                        it = sbq.pop_front();
                        chk($sformatf("R%0d stream bit", it.req), tx_bit, it.b);
                        chk("R7 frame_done timing", frame_done, it.last);
                        if (it.last) begin
                            active = 0;
                            phase = 0;
                            pending = frames_written > fs;
                            if (pending) chk("R8 back-to-back start", frame_adv, 1);
                        end
                    end
                end else begin
                    chk("R2 idle flag bit", tx_bit, FLAG[phase]);
                    chk("R7 no done while idle", frame_done, 0);
                    phase = (phase + 1) % 8;
                end
                if (frame_adv) begin
                    chk("R3 start on flag boundary", phase, 0);
                    active = 1;
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic held;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        for (int i = 0; i < 16; i++) flen[i] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 tx_bit", tx_bit, 1);
        chk("R1 rd_en", rd_en, 0);
        chk("R1 frame_adv", frame_adv, 0);
        chk("R1 frame_done", frame_done, 0);

        // R2 idle flags only
        repeat (160) @(negedge clk);
        chk("R2 no frame advance in idle", fs, 0);

        // R4 R6 mixed pattern
        tbuf[0] = 8'h00; tbuf[1] = 8'hA5; tbuf[2] = 8'h3C;
        queue_frame(3);
        wait_idle();

        // R5 dense ones and a flag octet inside the payload
        tbuf[0] = 8'hFF; tbuf[1] = 8'hFF; tbuf[2] = 8'h7E; tbuf[3] = 8'hF8;
        tbuf[4] = 8'h1F;
        queue_frame(5);
        wait_idle();

        // R6 empty frame: sixteen zero check bits
        queue_frame(0);
        wait_idle();

        // R8 two frames queued together
        tbuf[0] = 8'h12; tbuf[1] = 8'h34;
        queue_frame(2);
        tbuf[0] = 8'hBE; tbuf[1] = 8'hEF; tbuf[2] = 8'h01;
        queue_frame(3);
        wait_idle();

        // R9 strobe pause in mid-frame
        for (int i = 0; i < 4; i++) tbuf[i] = 8'h5A;
        queue_frame(4);
        while (!active) @(negedge clk);
        repeat (60) @(negedge clk);
        pause = 1;
        repeat (2) @(negedge clk);
        held = tx_bit;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            chk("R9 tx_bit held without strobe", tx_bit, held);
        end
        pause = 0;
        wait_idle();
        repeat (100) @(negedge clk);

        chk("R4 all bytes consumed", rp, 4);
        chk("R7 scoreboard drained", sbq.size(), 0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule